// File: doc/BRIEF.md
# Programmable ROM Mode Controller

This block is a synthesizable model of a word-wide one-time-programmable memory and the pin-level control that selects what it does. It takes three active-low controls: chip select `ce_n`, output gate `oe_n` and program strobe `pgm_n`. Two flags replace the analog high-voltage conditions: `vpp_hi` says the programming supply is raised, and `sig_hv` says the identification voltage is present on the lowest address pin. From these inputs the block picks one of seven behaviours: read, output off, standby, program, program verify, program inhibit and identification. It then drives a data bus with a per-bit enable that stands for tri-state.

Bits can only be cleared. A program strobe merges new data into the stored word with a bitwise AND. The only way back to all ones is the `erase` input. Erase, and also reset, starts a sequencer that writes all ones into one word per clock and raises `busy` while it runs. The array depth is `2**AW`. The full-size part uses `AW` = 16, and the default is kept small so the model stays fast.

Top module: `prom_ctl`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `sig_hv`=0, `dq` carries the word stored at `addr` and every bit of `dq_oe` is 1.
- R2: With `ce_n`=0 and `oe_n`=1, `dq_oe` is all zero and `dq` is zero. Outside a completed program strobe, the array keeps its contents.
- R3: With `ce_n`=1 and `vpp_hi`=0, `dq_oe` and `dq` are all zero, for either level of `oe_n`.
- R4: With `ce_n`=1 and `vpp_hi`=1, outputs are all zero and a strobe on `pgm_n` leaves the array unchanged.
- R5: A word is written at the clock edge where `pgm_n` is sampled 1 and, at the edge before it, the block was in program mode (`vpp_hi`=1, `ce_n`=0, `oe_n`=1, `pgm_n`=0). At that edge `ce_n`=0, `oe_n`=1 and `vpp_hi`=1 must still hold. The write uses the `addr` and `din` sampled at that edge.
- R6: A write stores old AND `din`, so no bit ever goes from 0 to 1. Holding `pgm_n` low for several cycles produces exactly one write, using the data present when the strobe rises.
- R7: With `vpp_hi`=1, `ce_n`=0, `oe_n`=0 and `pgm_n`=1, the stored word is driven (verify). If `pgm_n`=0 in the same setting, the outputs are off.
- R8: With `sig_hv`=1, `ce_n`=0 and `oe_n`=0, `dq` reads 0x008F when `addr[0]`=0 and 0x00D6 when `addr[0]`=1. Bits above 7 are zero and every bit of `dq_oe` is 1.
- R9: `erase` sampled 1 while `busy`=0 raises `busy` for exactly `2**AW` clock edges. During that time every word becomes 0xFFFF and program strobes are ignored. Reset starts the same sequence.
- R10: Outputs come from one register stage: `dq` and `dq_oe` reflect the inputs sampled at the previous rising edge. The bits of `dq_oe` are always all ones or all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; starts an erase |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| sig_hv | input | 1 | Identification voltage present |
| erase | input | 1 | Start clear-to-ones sequence |
| addr | input | AW (10) | Word address |
| din | input | DW (16) | Data to program |
| dq | output | DW (16) | Read data, zero when not driven |
| dq_oe | output | DW (16) | Per-bit drive enable |
| busy | output | 1 | Erase sequence running |

## Verification
Every output result falls due one rising edge after the inputs that cause it are sampled. A write becomes readable in the cycle after the edge on which the strobe rose. The driver applies inputs on the falling edge and queues the word and enable that the next rising edge must produce. The monitor compares them one time step after that edge, so every comparison lands in the cycle its result is due. The `busy` length is counted in samples taken after each edge. Seen this way, the reset-started erase shows one sample fewer than an `erase` request, because `busy` is already high before the first edge after reset.

// File: rtl/prom_pkg.sv
package prom_pkg;

   typedef enum logic [2:0] {
      MD_STANDBY,
      MD_INHIBIT,
      MD_DISABLE,
      MD_READ,
      MD_PROGRAM,
      MD_VERIFY,
      MD_SIGNATURE
   } prom_mode_e;

   localparam int          SIG_W     = 8;
   localparam logic [7:0]  SIG_MAKER = 8'h8F;
   localparam logic [7:0]  SIG_PART  = 8'hD6;

endpackage

// File: rtl/prom_mode_dec.sv
module prom_mode_dec
   import prom_pkg::*;
(
   input  logic       ce_n,
   input  logic       oe_n,
   input  logic       pgm_n,
   input  logic       vpp_hi,
   input  logic       sig_hv,
   output prom_mode_e mode
);

   always_comb begin
      if (ce_n) begin
         mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
      end else if (!oe_n && sig_hv) begin
         mode = MD_SIGNATURE;
      end else if (oe_n) begin
         mode = (vpp_hi && !pgm_n) ? MD_PROGRAM : MD_DISABLE;
      end else if (vpp_hi) begin
         mode = pgm_n ? MD_VERIFY : MD_DISABLE;
      end else begin
         mode = MD_READ;
      end
   end

endmodule

// File: rtl/prom_clr_seq.sv
module prom_clr_seq #(
   parameter int AW    = 10,
   parameter int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   output logic          busy,
   output logic [AW-1:0] waddr
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b1;
         waddr <= '0;
      end else if (busy) begin
         waddr <= waddr + 1'b1;
         if (waddr == LAST) begin
            busy <= 1'b0;
         end
      end else if (start) begin
         busy  <= 1'b1;
         waddr <= '0;
      end
   end

endmodule

// File: rtl/prom_array.sv
module prom_array #(
   parameter int DW    = 16,
   parameter int AW    = 10,
   parameter int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic          clr,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= clr ? {DW{1'b1}} : (mem[waddr] & wdata);
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/prom_ctl.sv
module prom_ctl
   import prom_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          pgm_n,
   input  logic          vpp_hi,
   input  logic          sig_hv,
   input  logic          erase,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dq,
   output logic [DW-1:0] dq_oe,
   output logic          busy
);

   localparam int DEPTH = 1 << AW;

   if (DW < SIG_W) begin : g_bad_dw
      $error("prom_ctl: DW must be at least the identification width");
   end
   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("prom_ctl: AW must lie in 1..16");
   end

   prom_mode_e    mode;
   logic          prog_q;
   logic          prog_wr;
   logic [AW-1:0] clr_addr;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] rdata;
   logic [DW-1:0] sig_word;
   logic [SIG_W-1:0] sig_code;

   prom_mode_dec u_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .pgm_n  (pgm_n),
      .vpp_hi (vpp_hi),
      .sig_hv (sig_hv),
      .mode   (mode)
   );

   prom_clr_seq #(.AW(AW), .DEPTH(DEPTH)) u_clr (
      .clk   (clk),
      .rst   (rst),
      .start (erase),
      .busy  (busy),
      .waddr (clr_addr)
   );

   // Strobe edge: program mode held at the previous edge, strobe now high.
   always_ff @(posedge clk) begin
      if (rst) begin
         prog_q <= 1'b0;
      end else begin
         prog_q <= (mode == MD_PROGRAM);
      end
   end

   assign prog_wr = prog_q && pgm_n && !ce_n && oe_n && vpp_hi && !busy;
   assign wr_addr = busy ? clr_addr : addr;

   prom_array #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_arr (
      .clk   (clk),
      .we    (busy | prog_wr),
      .clr   (busy),
      .waddr (wr_addr),
      .wdata (din),
      .raddr (addr),
      .rdata (rdata)
   );

   assign sig_code = addr[0] ? SIG_PART : SIG_MAKER;

   if (DW > SIG_W) begin : g_sig_wide
      assign sig_word = {{(DW-SIG_W){1'b0}}, sig_code};
   end else begin : g_sig_exact
      assign sig_word = sig_code;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dq    <= '0;
         dq_oe <= '0;
      end else begin
         unique case (mode)
            MD_READ, MD_VERIFY: begin
               dq    <= rdata;
               dq_oe <= '1;
            end
            MD_SIGNATURE: begin
               dq    <= sig_word;
               dq_oe <= '1;
            end
            default: begin
               dq    <= '0;
               dq_oe <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/prom_ctl_chk.sv
module prom_ctl_chk #(
   parameter int DW = 16,
   parameter int AW = 10
) (
   input logic          clk,
   input logic          rst,
   input logic          ce_n,
   input logic          oe_n,
   input logic          vpp_hi,
   input logic          sig_hv,
   input logic          a0,
   input logic [DW-1:0] dq,
   input logic [DW-1:0] dq_oe,
   input logic          busy
);

   localparam int DEPTH = 1 << AW;

   logic [AW:0] bcnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         bcnt <= '0;
      end else if (busy) begin
         bcnt <= bcnt + 1'b1;
      end else begin
         bcnt <= '0;
      end
   end

   // R3
   a_r3_standby_quiet: assert property (@(posedge clk) disable iff (rst)
      (ce_n && !vpp_hi) |=> (dq_oe == '0 && dq == '0));

   // R4
   a_r4_inhibit_quiet: assert property (@(posedge clk) disable iff (rst)
      (ce_n && vpp_hi) |=> (dq_oe == '0));

   // R2
   a_r2_gate_off: assert property (@(posedge clk) disable iff (rst)
      (!ce_n && oe_n) |=> (dq_oe == '0 && dq == '0));

   // R8
   a_r8_sig_upper: assert property (@(posedge clk) disable iff (rst)
      (!ce_n && !oe_n && sig_hv) |=> (dq[DW-1:8] == '0 && (&dq_oe)));

   a_r8_sig_maker: assert property (@(posedge clk) disable iff (rst)
      (!ce_n && !oe_n && sig_hv && !a0) |=> (dq[7:0] == 8'h8F));

   // R9
   a_r9_busy_len: assert property (@(posedge clk) disable iff (rst)
      (!busy && $past(busy)) |-> (bcnt == (AW+1)'(DEPTH)));

   // R10
   a_r10_oe_uniform: assert property (@(posedge clk) disable iff (rst)
      (dq_oe == '0 || (&dq_oe)));

endmodule

bind prom_ctl prom_ctl_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .ce_n   (ce_n),
   .oe_n   (oe_n),
   .vpp_hi (vpp_hi),
   .sig_hv (sig_hv),
   .a0     (addr[0]),
   .dq     (dq),
   .dq_oe  (dq_oe),
   .busy   (busy)
);

// File: tb/prom_ctl_bench.sv
module prom_ctl_bench;

   localparam int DW    = 16;
   localparam int AW    = 10;
   localparam int DEPTH = 1 << AW;

   typedef struct {
      logic          chk;
      logic [DW-1:0] xdq;
      logic          xoe;
      string         tag;
   } sb_item_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
   logic          vpp_hi = 1'b0, sig_hv = 1'b0, erase = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dq, dq_oe;
   logic          busy;

   logic [DW-1:0] model [DEPTH];
   sb_item_t      sbq[$];
   int            nvec = 0;
   int            nmis = 0;
   int            busy_seen = 0;

   always #10 clk = ~clk;

   prom_ctl #(.DW(DW), .AW(AW)) u_prom_ctl (
      .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
      .vpp_hi(vpp_hi), .sig_hv(sig_hv), .erase(erase), .addr(addr),
      .din(din), .dq(dq), .dq_oe(dq_oe), .busy(busy)
   );

   task automatic note(input bit ok, input string tag, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nmis++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Driver: apply one cycle of inputs and queue the result due after the next rising edge.
   task automatic cyc(input logic c, input logic o, input logic p, input logic v,
                      input logic s, input logic e, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic ck,
                      input logic [DW-1:0] xdq, input logic xoe, input string tag);
      sb_item_t it;
      @(negedge clk);
      ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; sig_hv = s; erase = e;
      addr = a; din = d;
      it.chk = ck; it.xdq = xdq; it.xoe = xoe; it.tag = tag;
      sbq.push_back(it);
   endtask

   task automatic idle();
      cyc(1, 1, 1, 0, 0, 0, '0, '0, 0, '0, 0, "idle");
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag);
      cyc(0, 0, 1, 0, 0, 0, a, '0, 1, model[a], 1, tag);
   endtask

   task automatic verify(input logic [AW-1:0] a, input string tag);
      cyc(0, 0, 1, 1, 0, 0, a, '0, 1, model[a], 1, tag);
   endtask

   // R5 R6: strobe low for nlow cycles with dlow, then rises with drise.
   task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] dlow,
                       input int nlow, input logic [DW-1:0] drise, input bit takes);
      for (int i = 0; i < nlow; i++) begin
         cyc(0, 1, 0, 1, 0, 0, a, dlow, 1, '0, 0, "R2 strobe low");
      end
      cyc(0, 1, 1, 1, 0, 0, a, drise, 1, '0, 0, "R2 strobe high");
      if (takes) model[a] = model[a] & drise;
   endtask

   // Monitor: compare just after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (!rst && busy) busy_seen++;
         if (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            if (it.chk) begin
               nvec++;
               if (dq !== it.xdq || dq_oe !== {DW{it.xoe}}) begin
                  nmis++;
                  $display("FAIL %s: actual dq=%h oe=%h expected dq=%h oe=%h",
                           it.tag, dq, dq_oe, it.xdq, {DW{it.xoe}});
               end
            end
         end
      end
   end

   initial begin
      #(20 * 150000);
      nmis++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      note(busy === 1'b1, "R9 busy in reset", int'(busy), 1);
      note(dq_oe === '0, "R3 outputs off in reset", int'(dq_oe), 0);
      rst = 1'b0;
      forever begin
         @(posedge clk); #2;
         if (!busy) break;
      end
      note(busy_seen == DEPTH - 1, "R9 reset erase length", busy_seen, DEPTH - 1);

      // R1 R9: erased word reads all ones
      rd(10'd5, "R1 R9 erased read");
      // R5 R7: program then verify and read
      prog(10'd5, 16'hA5A5, 1, 16'hA5A5, 1);
      verify(10'd5, "R7 verify after program");
      rd(10'd5, "R1 read after program");
      // R6: cannot set bits, result is AND
      prog(10'd5, 16'hFFFF, 1, 16'h0F0F, 1);
      rd(10'd5, "R6 AND merge 0505");
      // R6: held-low strobe, single write with rising-edge data
      prog(10'd7, 16'h00FF, 4, 16'hFFF0, 1);
      rd(10'd7, "R6 held low single write");
      // boundary: last address
      prog(10'(DEPTH - 1), 16'h1234, 1, 16'h1234, 1);
      rd(10'(DEPTH - 1), "R5 last address");
      rd(10'd0, "R5 neighbour untouched");
      // R2: gate off
      cyc(0, 1, 1, 0, 0, 0, 10'd5, '0, 1, '0, 0, "R2 output off");
      // R3: standby for both gate levels
      cyc(1, 0, 1, 0, 0, 0, 10'd5, '0, 1, '0, 0, "R3 standby oe low");
      cyc(1, 1, 1, 0, 0, 0, 10'd5, '0, 1, '0, 0, "R3 standby oe high");
      // R4: inhibited strobe
      cyc(1, 1, 0, 1, 0, 0, 10'd9, '0, 1, '0, 0, "R4 inhibit low");
      cyc(1, 1, 1, 1, 0, 0, 10'd9, '0, 1, '0, 0, "R4 inhibit high");
      rd(10'd9, "R4 inhibited word unchanged");
      // R7: verify setting with strobe low is off
      cyc(0, 0, 0, 1, 0, 0, 10'd5, '0, 1, '0, 0, "R7 verify strobe low off");
      // R8: identification
      cyc(0, 0, 1, 0, 1, 0, 10'd0, '0, 1, 16'h008F, 1, "R8 maker code");
      cyc(0, 0, 1, 0, 1, 0, 10'd1, '0, 1, 16'h00D6, 1, "R8 part code");
      cyc(0, 0, 1, 1, 1, 0, 10'd5, '0, 1, 16'h00D6, 1, "R8 code over array");
      cyc(1, 0, 1, 0, 1, 0, 10'd0, '0, 1, '0, 0, "R8 code needs select");
      // R10: address change shows one edge later
      rd(10'd7, "R10 latency a");
      rd(10'd5, "R10 latency b");
      // R9: erase with a strobe attempt while busy
      idle();
      busy_seen = 0;
      cyc(1, 1, 1, 0, 0, 1, '0, '0, 0, '0, 0, "erase");
      prog(10'd11, 16'h0000, 1, 16'h0000, 0);
      forever begin
         idle();
         @(posedge clk); #2;
         if (!busy) break;
      end
      for (int i = 0; i < DEPTH; i++) model[i] = '1;
      note(busy_seen == DEPTH, "R9 erase length", busy_seen, DEPTH);
      rd(10'd5, "R9 erased 5");
      rd(10'd7, "R9 erased 7");
      rd(10'd11, "R9 strobe during busy ignored");
      rd(10'(DEPTH - 1), "R9 erased last");
      idle();
      idle();
      @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
   end

endmodule